// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target on a Two-Wire Bus

This block is an I2C target that sits in front of a 2048-byte storage array. Clock and data lines are oversampled by the system clock. The block drives the data line only by pulling it low through an output enable, so the pad stays open-drain. A transaction begins with a START and a device byte. The device byte must match a fixed high bit and three strap inputs, one of which is compared inverted. The device byte also supplies the top three bits of the word address. In a write, a low address byte follows, and then up to a page of data bytes goes into a 16-byte staging buffer.

On STOP the staged bytes are written to the array in one cycle. A programmable busy interval then starts, and during it the block declines new transactions. In a read, bytes stream out from an internal pointer that advances after every byte and wraps at the top of the array. The pointer keeps its value between transactions, so a read with no address phase continues from where the last access ended. A write-protect input blocks the commit.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, sda_oe_o and busy_o are low, every array byte reads 0x00, and the address pointer is 0.
- R2: A falling data line while the clock is high is a START and a rising one is a STOP. Clock pulses seen in idle before any START get no acknowledge.
- R3: The device byte is matched only if bit 7 is 1 and bits 6:4 equal {strap_i[2], ~strap_i[1], strap_i[0]}. On a mismatch there is no acknowledge, and all bytes are ignored until the next START.
- R4: The block pulls SDA low during the 9th clock after a matched device byte, after the address byte and after every write data byte.
- R5: sda_oe_o changes only while SCL is low. It is updated after a falling edge, and incoming bits are sampled on rising edges.
- R6: In a write, device bits 3:1 give word address bits 10:8 and the next byte gives bits 7:0. The data bytes are staged, and on STOP every staged byte is written at once and busy_o rises.
- R7: The write address wraps inside its 16-byte page (address bits 3:0), so a byte beyond the 16th overwrites the one staged earlier at that position.
- R8: If wp_i is high when STOP arrives, the array is not changed and busy_o stays low.
- R9: busy_o stays high for BUSY_CYCLES clocks after a commit. During that time a device byte gets no acknowledge, and after it the same byte is acknowledged.
- R10: A read (device bit 0 = 1) sends bytes MSB first from successive addresses while the controller acknowledges. After a not-acknowledge the block releases SDA.
- R11: A sequential read continues from address 2047 to address 0.
- R12: A read with no address phase starts at the last accessed address plus one. Bits 3:1 of a read device byte are ignored.
- R13: A repeated START discards staged write bytes, so no commit happens and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Write protect, high blocks commits |
| busy_o | output | 1 | Internal write interval in progress |

## Verification
Two functions meet in one clock: the STOP that ends a write, and the commit that samples wp_i and flushes the staging buffer. The bench holds wp_i high through the STOP of one page write and low through another. It judges each case by the busy output and by reading the array back. A second collision comes from starting a new device byte straight after a commit STOP. The address decode then falls inside the busy window, and the missing acknowledge, followed by an acknowledge once the measured busy length ends, shows that both paths agree.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WA,
        ST_WA_ACK,
        ST_WD,
        ST_WD_ACK,
        ST_RD,
        ST_RACK
    } ee_state_e;

endpackage

// File: rtl/ee_bus_sampler.sv
module ee_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int DEPTH = SYNC_STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] scl;
        logic [DEPTH-1:0] sda;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[DEPTH-2:0], scl_i};
        s_d.sda = {s_q.sda[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;

    assign scl_now   = s_q.scl[DEPTH-2];
    assign scl_prev  = s_q.scl[DEPTH-1];
    assign sda_now   = s_q.sda[DEPTH-2];
    assign sda_prev  = s_q.sda[DEPTH-1];

    assign scl_lvl_o  = scl_now;
    assign sda_lvl_o  = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

    // R2: one line edge can never be both conditions
    a_r2_start_stop_apart: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !stop_o);

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_i,
    input  logic [PW-1:0]           wr_idx_i,
    input  logic [7:0]              wr_data_i,
    output logic [PAGE_BYTES*8-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o
);

    logic [7:0]            data_d [PAGE_BYTES];
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_d, mask_q;

    always_comb begin
        data_d = data_q;
        mask_d = mask_q;
        if (clr_i) begin
            mask_d = '0;
        end
        if (wr_i) begin
            data_d[wr_idx_i] = wr_data_i;
            mask_d[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                data_q[i] <= '0;
            end
        end else begin
            mask_q <= mask_d;
            data_q <= data_d;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign data_o[g*8 +: 8] = data_q[g];
    end
    assign mask_o = mask_q;

    // R13: a clear leaves no staged byte behind
    a_r13_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> (mask_o == '0));

endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 500,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr_i,
    output logic [7:0]              rd_data_o,
    input  logic                    commit_i,
    input  logic [AW-PW-1:0]        page_i,
    input  logic [PAGE_BYTES*8-1:0] page_data_i,
    input  logic [PAGE_BYTES-1:0]   page_mask_i,
    output logic                    busy_o
);

    logic [7:0]    mem_d [MEM_BYTES];
    logic [7:0]    mem_q [MEM_BYTES];
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_mask_i[i]) begin
                    mem_d[{page_i, PW'(i)}] = page_data_i[i*8 +: 8];
                end
            end
            cnt_d = CW'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = (cnt_q != '0);

    // R9: a commit always opens the busy window
    a_r9_commit_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> busy_o);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       busy_o
);
    import ee_pkg::*;

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int HW = AW - 8;

    typedef struct packed {
        ee_state_e     st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          rd_mode;
        logic          m_ack;
    } ctl_t;

    ctl_t r_d, r_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]              rd_data;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask;
    logic                    buf_clr, buf_wr, commit, busy_w;
    logic [PW-1:0]           buf_idx;
    logic [7:0]              buf_wdata;
    logic                    dev_match;

    ee_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (buf_clr),
        .wr_i     (buf_wr),
        .wr_idx_i (buf_idx),
        .wr_data_i(buf_wdata),
        .data_o   (buf_data),
        .mask_o   (buf_mask)
    );

    ee_mem_array #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr_i  (r_q.ptr),
        .rd_data_o  (rd_data),
        .commit_i   (commit),
        .page_i     (r_q.ptr[AW-1:PW]),
        .page_data_i(buf_data),
        .page_mask_i(buf_mask),
        .busy_o     (busy_w)
    );

    assign dev_match = r_q.sh[7] &&
                       (r_q.sh[6:4] == {strap_i[2], ~strap_i[1], strap_i[0]});

    always_comb begin
        r_d       = r_q;
        commit    = 1'b0;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        buf_idx   = r_q.ptr[PW-1:0];
        buf_wdata = r_q.sh;

        if (start_det) begin
            r_d.st  = ST_DEV;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
            buf_clr = 1'b1;
        end else if (stop_det) begin
            commit   = (buf_mask != '0) && !wp_i;
            buf_clr  = 1'b1;
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b0;
        end else begin
            case (r_q.st)
                ST_DEV, ST_WA, ST_WD: begin
                    if (scl_rise && (r_q.cnt < 4'd8)) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end
                    if (scl_fall && (r_q.cnt == 4'd8)) begin
                        if (r_q.st == ST_DEV) begin
                            if (dev_match && !busy_w) begin
                                r_d.oe      = 1'b1;
                                r_d.st      = ST_DEV_ACK;
                                r_d.rd_mode = r_q.sh[0];
                                if (!r_q.sh[0]) begin
                                    r_d.ptr[AW-1:8] = r_q.sh[HW:1];
                                end
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_WA) begin
                            r_d.ptr[7:0] = r_q.sh;
                            r_d.oe       = 1'b1;
                            r_d.st       = ST_WA_ACK;
                        end else begin
                            buf_wr = 1'b1;
                            r_d.ptr[PW-1:0] = r_q.ptr[PW-1:0] + 1'b1;
                            r_d.oe = 1'b1;
                            r_d.st = ST_WD_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rd_mode) begin
                            r_d.sh  = rd_data;
                            r_d.ptr = r_q.ptr + 1'b1;
                            r_d.oe  = ~rd_data[7];
                            r_d.st  = ST_RD;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_WA;
                        end
                    end
                end
                ST_WA_ACK, ST_WD_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        r_d.oe  = 1'b0;
                        r_d.st  = ST_WD;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = ST_RACK;
                        end else begin
                            r_d.cnt = r_q.cnt + 4'd1;
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.oe  = ~r_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.m_ack = ~sda_lvl;
                    end
                    if (scl_fall) begin
                        if (r_q.m_ack) begin
                            r_d.sh  = rd_data;
                            r_d.ptr = r_q.ptr + 1'b1;
                            r_d.oe  = ~rd_data[7];
                            r_d.st  = ST_RD;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, oe: 1'b0,
                     rd_mode: 1'b0, m_ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;
    assign busy_o   = busy_w;

    // R2: a START always reopens the device byte phase
    a_r2_start_enters_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.st == ST_DEV));

    // R5: the pad never moves while the clock stays high
    a_r5_oe_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe_o));

    // R6: busy can only begin right after a STOP
    a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> $past(stop_det));

    // R7: write data never leaves the page it started in
    a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WD) && ($past(r_q.st) == ST_WD_ACK))
        |-> (r_q.ptr[AW-1:PW] == $past(r_q.ptr[AW-1:PW])));

    // R8: protected STOPs never start a write interval
    a_r8_busy_needs_wp_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> !$past(wp_i));

    // R9: no device acknowledge during the busy window
    a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEV_ACK) |-> !busy_w);

endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;

    localparam int BUSY = 500;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       sda_oe, busy;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_eeprom_slave #(.BUSY_CYCLES(BUSY)) u_i2c_eeprom_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_oe_o(sda_oe),
        .strap_i (strap),
        .wp_i    (wp),
        .busy_o  (busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [2048];
    int busy_run = 0;
    int busy_last = 0;
    int oe_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    always @(negedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            busy_last <= busy_run;
            busy_run  <= 0;
        end
        if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_viol <= oe_viol + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] dev(input logic [10:0] a, input logic rw);
        return {4'b1010, a[10:8], rw};
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // page write; the bench model is updated only when the commit is allowed
    task automatic page_write(input logic [10:0] a, input int n, input logic [7:0] base,
                              input logic upd, input string tag);
        logic ack;
        bus_start();
        send_byte(dev(a, 1'b0), ack); chk({tag, " R4 dev ack"}, ack, 1);
        send_byte(a[7:0], ack);       chk({tag, " R4 addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), ack);
            chk({tag, " R4 data ack"}, ack, 1);
            if (upd) model[{a[10:4], 4'(a[3:0] + 4'(i))}] = base + 8'(i);
        end
        bus_stop();
    endtask

    task automatic read_random(input logic [10:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(dev(a, 1'b0), ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(dev(a, 1'b1), ack); chk({tag, " R10 read dev ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            chk(tag, v, model[11'(a + 11'(i))]);
        end
        bus_stop();
    endtask

    task automatic read_current(input logic [2:0] junk, input logic [10:0] a, input int n,
                                input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({4'b1010, junk, 1'b1}, ack); chk({tag, " dev ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            chk(tag, v, model[11'(a + 11'(i))]);
        end
        chk({tag, " R10 released"}, sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 busy after reset", busy, 0);
        read_current(3'b000, 11'h000, 2, "R1 pointer zero and data zero");
    endtask

    task automatic t_no_start();
        logic ack;
        send_byte(8'hA0, ack);
        chk("R2 no ack without START", ack, 0);
        bus_stop();
    endtask

    task automatic t_addr();
        logic ack;
        strap = 3'b101;
        bus_start();
        send_byte(8'hA0, ack); chk("R3 mismatch no ack", ack, 0);
        send_byte(8'hF0, ack); chk("R3 ignored until START", ack, 0);
        bus_start();
        send_byte(8'hF0, ack); chk("R3 inverted strap bit matches", ack, 1);
        bus_stop();
        chk("R3 no data no busy", busy, 0);
        bus_start();
        send_byte(8'h70, ack); chk("R3 bit7 zero rejected", ack, 0);
        bus_stop();
        strap = 3'b000;
    endtask

    task automatic t_page_write();
        page_write(11'h123, 3, 8'hC1, 1'b1, "R6");
        chk("R6 busy after commit", busy, 1);
        wait_idle();
        chk("R9 busy length", busy_last, BUSY);
        read_current(3'b000, 11'h126, 1, "R12 pointer after write");
        read_random(11'h122, 5, "R6 readback");
    endtask

    task automatic t_page_wrap();
        page_write(11'h20E, 18, 8'h40, 1'b1, "R7");
        wait_idle();
        read_random(11'h200, 16, "R7 wrapped page");
    endtask

    task automatic t_wp();
        wp = 1'b1;
        page_write(11'h450, 4, 8'h99, 1'b0, "R8");
        chk("R8 busy stays low", busy, 0);
        wp = 1'b0;
        read_random(11'h450, 4, "R8 array unchanged");
    endtask

    task automatic t_busy_nack();
        logic ack;
        page_write(11'h300, 1, 8'h5A, 1'b1, "R9");
        bus_start();
        send_byte(dev(11'h300, 1'b0), ack); chk("R9 nack while busy", ack, 0);
        bus_stop();
        wait_idle();
        bus_start();
        send_byte(dev(11'h300, 1'b0), ack); chk("R9 ack after busy", ack, 1);
        bus_stop();
        read_random(11'h300, 1, "R9 data kept");
    endtask

    task automatic t_seq_wrap();
        page_write(11'h7F8, 8, 8'hE0, 1'b1, "R11");
        wait_idle();
        page_write(11'h000, 2, 8'h11, 1'b1, "R11");
        wait_idle();
        read_random(11'h7FE, 4, "R11 wrap 2047 to 0");
        read_current(3'b101, 11'h002, 2, "R12 current read ignores bits 3:1");
    endtask

    task automatic t_restart();
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(dev(11'h510, 1'b0), ack);
        send_byte(8'h10, ack);
        send_byte(8'hAA, ack);
        send_byte(8'hBB, ack);
        bus_start();
        send_byte(dev(11'h000, 1'b1), ack); chk("R13 read after restart ack", ack, 1);
        recv_byte(v, 1'b0);
        chk("R13 pointer advanced by staged bytes", v, model[11'h512]);
        bus_stop();
        chk("R13 no commit", busy, 0);
        read_random(11'h510, 2, "R13 array unchanged");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_addr();
        t_page_write();
        t_page_wrap();
        t_wp();
        t_busy_nack();
        t_seq_wrap();
        t_restart();
        chk("R5 oe moved while SCL high", oe_viol, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

endmodule